// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter with one count input for each direction. A rising edge on the up input adds one, and a rising edge on the down input subtracts one. A parameter selects binary counting (0 to 15) or decade counting (0 to 9). A parallel preset copies a data word into the count. A master clear forces the count to zero.

The count inputs are treated as asynchronous levels. They are brought onto a free-running system clock through a two-flop synchronizer and edge-detected there, so every register in the block runs on that one clock. Each cycle the block applies at most one action, in this priority order: clear, then preset, then a count.

Two active-low outputs mark the terminal counts. Carry goes low while the count is at its maximum and the synchronized up input is low. Borrow goes low while the count is zero and the synchronized down input is low. Stages are chained by feeding carry into the up input of the next stage and borrow into its down input. This makes a multi-digit counter.

Top module: `updn_ctr`

## Requirements
- R1: After system reset the count is 0, and with both count inputs high carry_n_o and borrow_n_o are both 1.
- R2: While clr_i is 1 the count becomes 0 on the next clock, whatever load_n_i, data_i and the count inputs do.
- R3: While clr_i is 0 and load_n_i is 0, the count takes data_i on the next clock. Count-input edges during that time have no effect.
- R4: A rising edge on up_i while dn_i stays high adds one to the count. The new value appears on the third clock after the edge.
- R5: A rising edge on dn_i while up_i stays high subtracts one from the count. The new value appears on the third clock after the edge.
- R6: A rising edge on one count input while the other count input is low leaves the count unchanged.
- R7: Counting up from the maximum (15 binary, 9 decade) gives 0. Counting down from 0 gives the maximum.
- R8: carry_n_o is 0 only while the count equals the maximum and the synchronized up_i is low. It returns to 1 when up_i rises.
- R9: borrow_n_o is 0 only while the count is 0 and the synchronized dn_i is low. It returns to 1 when dn_i rises.
- R10: In decade mode, from an illegal state s (10 to 15), one up count gives ((s+1) mod 16) minus 10 when that value is at least 10, and the plain value otherwise; so 15 goes to 0. One down count from an illegal state gives 9.
- R11: With two decade stages chained through carry and borrow, counting up from 09 gives 10, and counting down from 10 gives 09.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| clr_i | input | 1 | Master clear, active high, top priority |
| load_n_i | input | 1 | Parallel preset, active low |
| data_i | input | WIDTH | Preset value |
| up_i | input | 1 | Up-count input; counts on its rising edge |
| dn_i | input | 1 | Down-count input; counts on its rising edge |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low terminal count for the up direction |
| borrow_n_o | output | 1 | Active-low terminal count for the down direction |

## Verification
A binary instance and a decade instance receive the same stream of clears, presets and single up and down pulses. Any step where the two modes should differ therefore shows up as a mismatch in one of them: the 9-to-0 wrap against the 9-to-10 step, and the different results from illegal decade states. Further patterns check three cases. A pulse is given while the opposite input is held low, which separates an ignored edge from a real count. Preset and clear are held over a count pulse to test priority. A terminal input is held low to test carry and borrow. A second decade stage fed by the first one's carry and borrow checks that a digit rollover moves exactly one step into the next stage, in each direction.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // Action the counter core applies in one cycle, chosen by priority.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } udc_op_e;

endpackage

// File: rtl/udc_sync.sv
// Multi-stage synchronizer for a group of independent level inputs.
module udc_sync #(
  parameter int          N      = 2,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE;
        else        stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/udc_ctl.sv
// Edge detection of the synchronized count inputs and per-cycle arbitration.
module udc_ctl
  import udc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    up_s_i,
  input  logic    dn_s_i,
  input  logic    clr_i,
  input  logic    load_n_i,
  output udc_op_e op_o
);

  logic up_d_q, dn_d_q;
  logic up_rise, dn_rise;
  logic inc_req, dec_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_d_q <= 1'b1;
      dn_d_q <= 1'b1;
    end else begin
      up_d_q <= up_s_i;
      dn_d_q <= dn_s_i;
    end
  end

  always_comb begin
    up_rise = up_s_i & ~up_d_q;
    dn_rise = dn_s_i & ~dn_d_q;
    // A count needs the opposite input held high; coincident rises cancel.
    inc_req = up_rise & dn_s_i & ~dn_rise;
    dec_req = dn_rise & up_s_i & ~up_rise;
  end

  always_comb begin
    if (clr_i)          op_o = OP_CLEAR;
    else if (!load_n_i) op_o = OP_LOAD;
    else if (inc_req)   op_o = OP_INC;
    else if (dec_req)   op_o = OP_DEC;
    else                op_o = OP_HOLD;
  end

endmodule

// File: rtl/udc_core.sv
// Count register with next-state logic; the mode is picked at elaboration.
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  udc_op_e          op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o
);

  localparam int               MODULUS = DECADE ? 10 : (1 << WIDTH);
  localparam logic [WIDTH-1:0] MAXV    = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] inc_val, dec_val;
  logic             cnt_en;

  if (DECADE) begin : g_decade
    localparam logic [WIDTH-1:0] MODV = WIDTH'(MODULUS);
    logic [WIDTH-1:0] raw_inc;
    always_comb begin
      raw_inc = cnt_q + 1'b1;
      // Folding by the modulus brings 9 and every illegal state back in range.
      if (raw_inc >= MODV) inc_val = raw_inc - MODV;
      else                 inc_val = raw_inc;
      if (cnt_q == '0 || cnt_q > MAXV) dec_val = MAXV;
      else                             dec_val = cnt_q - 1'b1;
    end
  end else begin : g_binary
    always_comb begin
      inc_val = cnt_q + 1'b1;
      dec_val = cnt_q - 1'b1;
    end
  end

  always_comb begin
    cnt_en = (op_i != OP_HOLD);
    unique case (op_i)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = data_i;
      OP_INC:   cnt_d = inc_val;
      OP_DEC:   cnt_d = dec_val;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/udc_term.sv
// Terminal-count outputs, gated by the low phase of the matching count input.
module udc_term #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] MAXV  = '1
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_s_i,
  input  logic             dn_s_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic at_top, at_zero;

  always_comb begin
    at_top     = (count_i == MAXV);
    at_zero    = (count_i == '0);
    carry_n_o  = ~(at_top  & ~up_s_i);
    borrow_n_o = ~(at_zero & ~dn_s_i);
  end

endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  localparam int               MODULUS = DECADE ? 10 : (1 << WIDTH);
  localparam logic [WIDTH-1:0] MAXV    = WIDTH'(MODULUS - 1);

  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  logic [1:0] cnt_in_s;
  logic       up_s, dn_s;
  udc_op_e    op;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  udc_sync #(.N(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({up_i, dn_i}),
    .q_o   (cnt_in_s)
  );
  assign up_s = cnt_in_s[1];
  assign dn_s = cnt_in_s[0];

  udc_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .clr_i    (clr_i),
    .load_n_i (load_n_i),
    .op_o     (op)
  );

  udc_core #(.WIDTH(WIDTH), .DECADE(DECADE)) u_core (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .op_i    (op),
    .data_i  (data_i),
    .count_o (count_o)
  );

  udc_term #(.WIDTH(WIDTH), .MAXV(MAXV)) u_term (
    .count_i    (count_o),
    .up_s_i     (up_s),
    .dn_s_i     (dn_s),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

endmodule

// File: rtl/updn_ctr_chk.sv
module updn_ctr_chk
  import udc_pkg::*;
#(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] MAXV  = '1
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             clr_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o,
  input udc_op_e          op
);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    clr_i |=> (count_o == '0));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clr_i && !load_n_i) |=> (count_o == $past(data_i)));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_INC && count_o < MAXV) |=> (count_o == $past(count_o) + 1'b1));

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_DEC && count_o != '0 && count_o <= MAXV) |=> (count_o == $past(count_o) - 1'b1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_HOLD) |=> $stable(count_o));

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_INC || op == OP_DEC) |=> (count_o <= MAXV));

  // R8
  carry_top_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !carry_n_o |-> (count_o == MAXV));

  // R9
  borrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !borrow_n_o |-> (count_o == '0));

endmodule

bind updn_ctr updn_ctr_chk #(.WIDTH(WIDTH), .MAXV(MAXV)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .clr_i      (clr_i),
  .load_n_i   (load_n_i),
  .data_i     (data_i),
  .count_o    (count_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o),
  .op         (op)
);

// File: tb/updn_ctr_bench.sv
`timescale 1ns/1ps
module updn_ctr_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr, load_n, up, dn;
  logic [3:0] data;
  logic [3:0] cnt_lo, cnt_hi, cnt_b;
  logic       cy_lo, bw_lo, cy_hi, bw_hi, cy_b, bw_b;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // Decade low digit, chained into a decade high digit.
  updn_ctr #(.WIDTH(4), .DECADE(1'b1)) u_updn_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_n_i(load_n), .data_i(data),
    .up_i(up), .dn_i(dn), .count_o(cnt_lo), .carry_n_o(cy_lo), .borrow_n_o(bw_lo));

  updn_ctr #(.WIDTH(4), .DECADE(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_n_i(1'b1), .data_i(4'd0),
    .up_i(cy_lo), .dn_i(bw_lo), .count_o(cnt_hi), .carry_n_o(cy_hi), .borrow_n_o(bw_hi));

  // Binary instance on the same stimulus.
  updn_ctr #(.WIDTH(4), .DECADE(1'b0)) u_bin (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_n_i(load_n), .data_i(data),
    .up_i(up), .dn_i(dn), .count_o(cnt_b), .carry_n_o(cy_b), .borrow_n_o(bw_b));

  // {op, data, decade result, binary result}; op 0 clear, 1 preset, 2 up, 3 down.
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 4'd0,  4'd0,  4'd0 },
    {2'd2, 4'd0,  4'd1,  4'd1 },
    {2'd3, 4'd0,  4'd0,  4'd0 },
    {2'd3, 4'd0,  4'd9,  4'd15},
    {2'd2, 4'd0,  4'd0,  4'd0 },
    {2'd1, 4'd8,  4'd8,  4'd8 },
    {2'd2, 4'd0,  4'd9,  4'd9 },
    {2'd2, 4'd0,  4'd0,  4'd10},
    {2'd1, 4'd13, 4'd13, 4'd13},
    {2'd2, 4'd0,  4'd4,  4'd14},
    {2'd1, 4'd15, 4'd15, 4'd15},
    {2'd2, 4'd0,  4'd0,  4'd0 },
    {2'd1, 4'd12, 4'd12, 4'd12},
    {2'd3, 4'd0,  4'd9,  4'd11},
    {2'd1, 4'd10, 4'd10, 4'd10},
    {2'd2, 4'd0,  4'd1,  4'd11},
    {2'd1, 4'd11, 4'd11, 4'd11},
    {2'd3, 4'd0,  4'd9,  4'd10},
    {2'd1, 4'd14, 4'd14, 4'd14},
    {2'd2, 4'd0,  4'd5,  4'd15},
    {2'd0, 4'd0,  4'd0,  4'd0 }
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [3:0] d);
    @(negedge clk); load_n = 1'b0; data = d;
    @(negedge clk); load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_up();
    @(negedge clk); up = 1'b0;
    wait_n(4); up = 1'b1;
    wait_n(5);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn = 1'b0;
    wait_n(4); dn = 1'b1;
    wait_n(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; load_n = 1'b1; up = 1'b1; dn = 1'b1; data = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    chk("R1 dec count", cnt_lo, 0);
    chk("R1 bin count", cnt_b, 0);
    chk("R1 carry", cy_lo, 1);
    chk("R1 borrow", bw_b, 1);

    // Vector table: R2 clear, R3 preset, R4 up, R5 down, R7 wraps, R10 illegal decade states
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][13:12])
        2'd0: do_clear();
        2'd1: do_load(VEC[i][11:8]);
        2'd2: pulse_up();
        default: pulse_dn();
      endcase
      case (VEC[i][13:12])
        2'd0: begin chk("R2 dec", cnt_lo, VEC[i][7:4]); chk("R2 bin", cnt_b, VEC[i][3:0]); end
        2'd1: begin chk("R3 dec", cnt_lo, VEC[i][7:4]); chk("R3 bin", cnt_b, VEC[i][3:0]); end
        2'd2: begin chk("R4 R10 dec", cnt_lo, VEC[i][7:4]); chk("R4 R7 bin", cnt_b, VEC[i][3:0]); end
        default: begin chk("R5 R10 dec", cnt_lo, VEC[i][7:4]); chk("R5 R7 bin", cnt_b, VEC[i][3:0]); end
      endcase
      chk("R8 idle carry", cy_lo & cy_b, 1);
      chk("R9 idle borrow", bw_lo & bw_b, 1);
    end

    // R2 clear beats a preset in the same cycle
    do_load(4'd3);
    @(negedge clk); clr = 1'b1; load_n = 1'b0; data = 4'd7;
    @(negedge clk); clr = 1'b0; load_n = 1'b1;
    @(negedge clk);
    chk("R2 over load", cnt_lo, 0);

    // R3 a held preset ignores a count pulse
    @(negedge clk); load_n = 1'b0; data = 4'd6; up = 1'b0;
    wait_n(4); up = 1'b1;
    wait_n(5);
    chk("R3 held", cnt_lo, 6);
    load_n = 1'b1;
    @(negedge clk);
    chk("R3 after", cnt_b, 6);

    // R6 up pulse while down input is low is ignored
    do_load(4'd5);
    dn = 1'b0; wait_n(4);
    up = 1'b0; wait_n(4); up = 1'b1; wait_n(5);
    chk("R6 dec", cnt_lo, 5);
    chk("R6 bin", cnt_b, 5);
    dn = 1'b1; wait_n(5);
    chk("R5 release", cnt_lo, 4);

    // R8 decade carry at 9
    do_load(4'd9);
    up = 1'b0; wait_n(4);
    chk("R8 dec low", cy_lo, 0);
    chk("R8 bin high", cy_b, 1);
    up = 1'b1; wait_n(5);
    chk("R8 dec back", cy_lo, 1);
    chk("R7 dec wrap", cnt_lo, 0);

    // R8 binary carry at 15
    do_load(4'd15);
    up = 1'b0; wait_n(4);
    chk("R8 bin low", cy_b, 0);
    up = 1'b1; wait_n(5);
    chk("R7 bin wrap", cnt_b, 0);
    chk("R8 bin back", cy_b, 1);

    // R9 borrow at zero
    do_clear();
    dn = 1'b0; wait_n(4);
    chk("R9 dec low", bw_lo, 0);
    chk("R9 bin low", bw_b, 0);
    dn = 1'b1; wait_n(5);
    chk("R9 dec back", bw_lo, 1);
    chk("R7 dec under", cnt_lo, 9);
    chk("R7 bin under", cnt_b, 15);

    // R10 down from an illegal state
    do_load(4'd15);
    pulse_dn();
    chk("R10 dec down", cnt_lo, 9);
    chk("R10 bin down", cnt_b, 14);

    // R11 two-stage decade cascade
    do_clear();
    do_load(4'd9);
    pulse_up(); wait_n(6);
    chk("R11 up lo", cnt_lo, 0);
    chk("R11 up hi", cnt_hi, 1);
    pulse_dn(); wait_n(6);
    chk("R11 dn lo", cnt_lo, 9);
    chk("R11 dn hi", cnt_hi, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule